// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block sits between the execution datapath of a single-cycle 8-bit controller and a dual-ported data RAM. It turns the 7-bit file field of an instruction into a 9-bit data address. Outside file 0 it takes the upper bits from a two-bit bank select. For file 0, the indirect pseudo-register, it uses a one-bit indirect bank bit followed by an 8-bit pointer register.

The read address is formed combinationally in the decode cycle. The same address travels one register stage into the execute cycle, where it becomes the write address, so one instruction's write and the next one's read share a clock. An indirect access whose pointer names the pseudo-register itself is suppressed. Such a read returns 0x00 and such a write never reaches the RAM. When a write and a read hit the same address in one cycle, the write data is forwarded to the read data returned in the next cycle.

Top module: `dmem_addr_gen`

## Requirements
- R1: When `fileSel` is not 0, `rdAddr` equals `{bankSel, fileSel}` in the same cycle.
- R2: When `fileSel` is 0 (indirect), `rdAddr` equals `{indBank, filePtr}` in the same cycle, whatever the bank select.
- R3: `ramOe` is high exactly when `rdReq` is high and the access is not self-referencing. An access is self-referencing when `fileSel` is 0 and `filePtr[6:0]` is 0, in either bank.
- R4: A self-referencing read drives `ramOe` low, and `rdData` is 0x00 in the following cycle.
- R5: `wrAddr` in cycle t+1 equals the address formed from the decode inputs in cycle t.
- R6: `ramWe` in cycle t+1 equals `wrReq` of cycle t, except that a self-referencing write leaves `ramWe` low.
- R7: `ramDataO` equals `wrData` in every cycle.
- R8: For a normal read in cycle t, `rdData` in cycle t+1 equals `ramDataI` returned by the RAM for `rdAddr` of cycle t.
- R9: If in cycle t `ramWe` and `ramOe` are both high and `wrAddr` equals `rdAddr`, then `rdData` in cycle t+1 equals `wrData` of cycle t.
- R10: While `rstN` is low, `ramWe` is low and `wrAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fileSel | input | 7 | File field of the decoding instruction |
| rdReq | input | 1 | Decoding instruction reads its file |
| wrReq | input | 1 | Decoding instruction writes its file |
| bankSel | input | 2 | Direct bank select bits |
| indBank | input | 1 | Indirect bank bit |
| filePtr | input | 8 | Pointer register |
| wrData | input | 8 | Result to write in the execute cycle |
| ramDataI | input | 8 | Read data from RAM, one cycle after the address |
| rdAddr | output | 9 | RAM read address |
| wrAddr | output | 9 | RAM write address |
| ramWe | output | 1 | RAM write enable |
| ramOe | output | 1 | RAM read enable |
| ramDataO | output | 8 | RAM write data |
| rdData | output | 8 | Read data to the datapath |

## Verification
The bench builds the block with its default widths: a 7-bit file field, 2 bank bits and an 8-bit pointer, so the address space has 512 locations. That space is small enough to sweep every direct bank and file pair, and every indirect bank and pointer pair, against a behavioural dual-ported RAM that returns old data on a collision. A run of back-to-back writes and reads to one address exercises forwarding. The sweep also crosses both self-referencing pointers, 0x00 and 0x80, with reads and writes.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef struct packed {
    logic useInd;   // decode: take the pointer path
    logic fwdCap;   // decode: capture write data for forwarding
    logic rdZero;   // execute: force read data to zero
    logic fwdUse;   // execute: return captured write data
  } dagStrobes_t;
endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
#(
  parameter int FILE_W   = 7,
  parameter int IND_FILE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILE_W-1:0] fileSel,
  input  logic [FILE_W-1:0] ptrFile,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              addrMatch,
  output logic              ramOe,
  output logic              ramWe,
  output dagStrobes_t       strb
);
  localparam logic [FILE_W-1:0] IndCode = FILE_W'(IND_FILE);

  logic isInd, isSelf, weQ, rdZeroQ, fwdQ, fwdHit;

  assign isInd  = (fileSel == IndCode);
  assign isSelf = isInd && (ptrFile == IndCode);
  assign ramOe  = rdReq && !isSelf;
  assign ramWe  = weQ;
  assign fwdHit = weQ && ramOe && addrMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ     <= 1'b0;
      rdZeroQ <= 1'b0;
      fwdQ    <= 1'b0;
    end else begin
      weQ     <= wrReq && !isSelf;
      rdZeroQ <= rdReq && isSelf;
      fwdQ    <= fwdHit;
    end
  end

  always_comb begin
    strb.useInd = isInd;
    strb.fwdCap = fwdHit;
    strb.rdZero = rdZeroQ;
    strb.fwdUse = fwdQ;
  end
endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
#(
  parameter int FILE_W = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dagStrobes_t       strb,
  input  logic [FILE_W-1:0] fileSel,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              indBank,
  input  logic [PTR_W-1:0]  filePtr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ramDataI,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              addrMatch,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] directAddr, indAddr;
  logic [DATA_W-1:0] fwdDataQ;

  assign directAddr = {bankSel, fileSel};
  assign indAddr    = {indBank, filePtr};
  assign rdAddr     = strb.useInd ? indAddr : directAddr;
  assign addrMatch  = (wrAddr == rdAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr   <= '0;
      fwdDataQ <= '0;
    end else begin
      wrAddr <= rdAddr;
      if (strb.fwdCap) fwdDataQ <= wrData;
    end
  end

  always_comb begin
    if (strb.rdZero)      rdData = '0;
    else if (strb.fwdUse) rdData = fwdDataQ;
    else                  rdData = ramDataI;
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dag_pkg::*;
#(
  parameter int FILE_W   = 7,
  parameter int BANK_W   = 2,
  parameter int PTR_W    = 8,
  parameter int DATA_W   = 8,
  parameter int IND_FILE = 0,
  localparam int ADDR_W  = BANK_W + FILE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILE_W-1:0] fileSel,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              indBank,
  input  logic [PTR_W-1:0]  filePtr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ramDataI,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              ramWe,
  output logic              ramOe,
  output logic [DATA_W-1:0] ramDataO,
  output logic [DATA_W-1:0] rdData
);
  dagStrobes_t strb;
  logic        addrMatch;

  assign ramDataO = wrData;

  dag_ctrl #(.FILE_W(FILE_W), .IND_FILE(IND_FILE)) u_ctrl (
    .clk(clk), .rstN(rstN), .fileSel(fileSel),
    .ptrFile(filePtr[FILE_W-1:0]), .rdReq(rdReq), .wrReq(wrReq),
    .addrMatch(addrMatch), .ramOe(ramOe), .ramWe(ramWe), .strb(strb)
  );

  dag_datapath #(.FILE_W(FILE_W), .BANK_W(BANK_W), .PTR_W(PTR_W),
                 .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fileSel(fileSel),
    .bankSel(bankSel), .indBank(indBank), .filePtr(filePtr),
    .wrData(wrData), .ramDataI(ramDataI), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .addrMatch(addrMatch), .rdData(rdData)
  );
endmodule

// File: rtl/dmem_addr_gen_chk.sv
module dmem_addr_gen_chk #(
  parameter int FILE_W = 7,
  parameter int BANK_W = 2,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [FILE_W-1:0] fileSel,
  input logic              rdReq,
  input logic              wrReq,
  input logic              indBank,
  input logic [PTR_W-1:0]  filePtr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              ramWe,
  input logic              ramOe,
  input logic [DATA_W-1:0] rdData
);
  logic selfRef;
  assign selfRef = (fileSel == '0) && (filePtr[FILE_W-1:0] == '0);

  a_r1_direct_file: assert property (@(posedge clk) disable iff (!rstN)
    (fileSel != '0) |-> (rdAddr[FILE_W-1:0] == fileSel));
  a_r2_indirect_addr: assert property (@(posedge clk) disable iff (!rstN)
    (fileSel == '0) |-> (rdAddr == {indBank, filePtr}));
  a_r3_oe_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |-> !ramOe);
  a_r4_self_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && selfRef) |=> (rdData == '0));
  a_r5_wraddr_pipe: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wrAddr == $past(rdAddr)));
  a_r6_self_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && selfRef) |=> !ramWe);
  a_r9_forward: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramOe && (wrAddr == rdAddr)) |=> (rdData == $past(wrData)));
endmodule

bind dmem_addr_gen dmem_addr_gen_chk #(
  .FILE_W(FILE_W), .BANK_W(BANK_W), .PTR_W(PTR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .fileSel(fileSel), .rdReq(rdReq), .wrReq(wrReq),
  .indBank(indBank), .filePtr(filePtr), .wrData(wrData), .rdAddr(rdAddr),
  .wrAddr(wrAddr), .ramWe(ramWe), .ramOe(ramOe), .rdData(rdData)
);

// File: tb/test_dmem_addr_gen.sv
module test_dmem_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] fileSel = '0;
  logic       rdReq = 1'b0, wrReq = 1'b0;
  logic [1:0] bankSel = '0;
  logic       indBank = 1'b0;
  logic [7:0] filePtr = '0, wrData = '0, ramDataI;
  logic [8:0] rdAddr, wrAddr;
  logic       ramWe, ramOe;
  logic [7:0] ramDataO, rdData;

  logic [7:0] mem [512];
  logic [7:0] shadow [512];
  logic [7:0] ramQ = '0;
  int checks = 0, fails = 0;

  logic [8:0] pWa = '0;
  logic       pWe = 1'b0, pRdValid = 1'b0;
  logic [7:0] pRd = '0;
  string      pTag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ramDataI = ramQ;

  always @(posedge clk) begin
    if (ramWe) mem[wrAddr] <= ramDataO;
    if (ramOe) ramQ <= mem[rdAddr];
  end

  dmem_addr_gen i_dmem_addr_gen (
    .clk(clk), .rstN(rstN), .fileSel(fileSel), .rdReq(rdReq), .wrReq(wrReq),
    .bankSel(bankSel), .indBank(indBank), .filePtr(filePtr), .wrData(wrData),
    .ramDataI(ramDataI), .rdAddr(rdAddr), .wrAddr(wrAddr), .ramWe(ramWe),
    .ramOe(ramOe), .ramDataO(ramDataO), .rdData(rdData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: inputs set after negedge, outputs checked before posedge.
  task automatic cycle(input logic [6:0] f, input logic [1:0] b, input logic ib,
                       input logic [7:0] p, input logic rr, input logic wr,
                       input logic [7:0] wd);
    logic       ind, self, expOe, expWe, fwd;
    logic [8:0] ea;
    @(negedge clk);
    fileSel = f; bankSel = b; indBank = ib; filePtr = p;
    rdReq = rr; wrReq = wr; wrData = wd;
    #1;
    ind   = (f == 7'd0);
    ea    = ind ? {ib, p} : {b, f};
    self  = ind && (p[6:0] == 7'd0);
    expOe = rr && !self;
    expWe = wr && !self;
    chk(ind ? "R2" : "R1", rdAddr, ea);
    chk(self ? "R4" : "R3", ramOe, expOe);
    chk("R5", wrAddr, pWa);
    chk("R6", ramWe, pWe);
    chk("R7", ramDataO, wd);
    if (pRdValid) chk(pTag, rdData, pRd);
    fwd = pWe && expOe && (pWa == ea);
    if (rr && self)  begin pRd = 8'h00; pTag = "R4"; end
    else if (fwd)    begin pRd = wd; pTag = "R9"; end
    else             begin pRd = shadow[ea]; pTag = "R8"; end
    if (pWe) shadow[pWa] = wd;
    pWa = ea; pWe = expWe; pRdValid = rr;
  endtask

  initial begin
    for (int a = 0; a < 512; a++) begin
      mem[a] = 8'(a ^ 8'h5A);
      shadow[a] = 8'(a ^ 8'h5A);
    end
    repeat (2) @(negedge clk);
    #1;
    chk("R10", ramWe, 0);
    chk("R10", wrAddr, 0);
    @(negedge clk);
    rstN = 1'b1;
    // Direct sweep: every bank and file pair
    for (int i = 0; i < 512; i++)
      cycle(7'(i), 2'(i >> 7), 1'(i), 8'(i * 37), 1'b1, 1'(i[1] ^ i[3]), 8'(i * 13 + 1));
    // Indirect sweep: every indirect bank and pointer pair
    for (int i = 0; i < 512; i++)
      cycle(7'd0, 2'(i * 3), 1'(i >> 8), 8'(i), 1'(i[0] | i[2]), 1'(!i[1]), 8'(i * 7 + 3));
    // Self-referencing pointers with both requests high
    cycle(7'd0, 2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA5);
    cycle(7'd0, 2'd2, 1'b1, 8'h80, 1'b1, 1'b1, 8'hC3);
    cycle(7'd0, 2'd3, 1'b1, 8'h00, 1'b1, 1'b1, 8'h11);
    // Back-to-back read/write of one address, direct then indirect
    for (int i = 0; i < 8; i++)
      cycle(7'd5, 2'd1, 1'b0, 8'h00, 1'b1, 1'b1, 8'(8'h40 + i));
    for (int i = 0; i < 8; i++)
      cycle(7'd0, 2'd0, 1'b1, 8'h85, 1'b1, 1'b1, 8'(8'h90 + i));
    // Drain and read back written locations
    cycle(7'd5, 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    cycle(7'd0, 2'd0, 1'b1, 8'h85, 1'b1, 1'b0, 8'h00);
    cycle(7'd1, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    cycle(7'd1, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule